// File: doc/BRIEF.md
# Two-Level Page Walker With Permission Check and Atomic Flag Update

This block resolves a translation miss. It accepts a miss request that carries a 32-bit virtual address, a write flag and a problem-state (user mode) flag. It picks a root table: the per-task root for low addresses and the kernel root for addresses at or above `KBASE`. It then reads a root entry and takes the leaf-table base from that entry. Next it loads the leaf entry with a reservation and compares the requested permission set against the entry.

When the access is allowed, the walker writes the leaf back with a conditional store. The written value has the referenced and hash-present flags set, and also the changed flag when the access is a write. If the reservation has been lost, the walker loads the leaf again and repeats the check. A successful walk produces a one-cycle grant. The grant carries the virtual address, the leaf value read before the update and the leaf value written, which an insertion stage downstream uses. A missing mapping or a denied access produces a one-cycle fault and stores nothing. Each grant also advances a reload counter.

The controller is a single state machine with these states. `S_IDLE` waits for a request. `S_ROOT` reads the root entry. `S_LR` does the reserved leaf load and the permission check. `S_SC` does the conditional store. `S_GRANT` and `S_FAULT` each last one cycle and report the result. The transitions are as follows.
- Request: `S_IDLE`→`S_ROOT`.
- Root ack with a nonzero base: `S_ROOT`→`S_LR`.
- Root ack with a zero base: `S_ROOT`→`S_FAULT`.
- Leaf ack with the access allowed: `S_LR`→`S_SC`.
- Leaf ack with the access denied: `S_LR`→`S_FAULT`.
- Store succeeded: `S_SC`→`S_GRANT`.
- Reservation lost: `S_SC`→`S_LR`.
- After the report: `S_GRANT`/`S_FAULT`→`S_IDLE`.

Top module: `ptw_walker`

## Requirements
- R1: The root read (op 0) goes to address {root[31:12], va[31:22], 2'b00}. The root is `kern_root` when va >= KBASE and `task_root` otherwise; the choice is made when the request is accepted.
- R2: If bits 31:12 of the root entry are all zero, the walk ends in `fault_valid`, and the walk makes no further memory access.
- R3: The leaf is fetched with a reserved load (op 1) at {entry[31:12], va[21:12], 2'b00}; the low 12 bits of the root entry are ignored.
- R4: The requested set always contains the present flag (0x001). It contains the user flag (0x004) when va < KBASE or `req_user_mode` is 1, and the write flag (0x400) when `req_write` is 1.
- R5: If any requested flag is missing from the leaf, the walk ends in `fault_valid` and issues no conditional store.
- R6: When the access is allowed, the conditional store (op 2) writes the leaf OR 0x100 (referenced) OR 0x002 (hash-present), and also OR 0x080 (changed) on a write.
- R7: When the store is acknowledged with `mem_sc_ok`=0, the reserved load and the permission check are repeated. The repeated check may end in a fault.
- R8: A successful walk raises `grant_valid` for exactly one cycle. In that cycle `grant_vaddr` is the request address, `grant_old` is the leaf as last loaded and `grant_new` is the value stored. `grant_valid` and `fault_valid` are never high together.
- R9: `reload_count` starts at zero and rises by one, modulo 2^CNT_W, for each grant. It does not change on a fault.
- R10: At most one memory request is outstanding. `mem_req` stays high, with `mem_addr` and `mem_op` stable, until the cycle in which `mem_ack` is high.
- R11: A request is taken only while `busy` is low. A `req_valid` pulse while busy, including during the grant or fault cycle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_vaddr | input | 32 | Missing virtual address |
| req_write | input | 1 | Access is a write |
| req_user_mode | input | 1 | Processor is in problem (user) state |
| busy | output | 1 | Walk in progress; requests ignored |
| task_root | input | 32 | Per-task root table base (4 KB aligned) |
| kern_root | input | 32 | Kernel root table base (4 KB aligned) |
| mem_req | output | 1 | Memory request, held until ack |
| mem_op | output | 2 | 0 read, 1 reserved load, 2 conditional store |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Request complete (one cycle) |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_sc_ok | input | 1 | Conditional store took effect, valid with ack |
| grant_valid | output | 1 | Walk succeeded |
| grant_vaddr | output | 32 | Address of the granted walk |
| grant_old | output | 32 | Leaf before update |
| grant_new | output | 32 | Leaf after update |
| fault_valid | output | 1 | Walk failed (no mapping or denied) |
| reload_count | output | CNT_W | Count of grants |

## Verification
Two events can coincide with a conditional-store outcome. The first is a lost reservation while the leaf changes underneath the walker. The bench memory fails the store and, in the same response, removes the write flag from the leaf. The walk is then expected to repeat its load and end in a fault with the counter unchanged. The second is a new request that arrives during the busy period or in the grant cycle itself. That pulse must start no second walk, which the bench judges by the root-read count and by `busy` in the following cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ROOT  = 3'd1,
        S_LR    = 3'd2,
        S_SC    = 3'd3,
        S_GRANT = 3'd4,
        S_FAULT = 3'd5
    } walk_state_t;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_LDRES  = 2'd1;
    localparam logic [1:0] OP_STCOND = 2'd2;

    localparam logic [31:0] F_PRESENT  = 32'h0000_0001;
    localparam logic [31:0] F_HASHED   = 32'h0000_0002;
    localparam logic [31:0] F_USER     = 32'h0000_0004;
    localparam logic [31:0] F_DIRTY    = 32'h0000_0080;
    localparam logic [31:0] F_ACCESSED = 32'h0000_0100;
    localparam logic [31:0] F_WRITE    = 32'h0000_0400;

endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
    parameter int PAGE_W     = 12,
    parameter int ROOT_IDX_W = 10,
    parameter int LEAF_IDX_W = 10,
    localparam int BASE_W    = 32 - PAGE_W
) (
    input  logic              leaf_phase,
    input  logic [31:0]       root_base,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [31:0]       vaddr,
    output logic [31:0]       addr
);
    logic [31:0] root_addr;
    logic [31:0] leaf_addr;

    // entries are 4 bytes, so each index is shifted left by two
    assign root_addr = {root_base[31:PAGE_W], {PAGE_W{1'b0}}}
                     | (32'(vaddr[31 -: ROOT_IDX_W]) << 2);
    assign leaf_addr = {tbl_base, {PAGE_W{1'b0}}}
                     | (32'(vaddr[PAGE_W +: LEAF_IDX_W]) << 2);
    assign addr      = leaf_phase ? leaf_addr : root_addr;
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
#(
    parameter logic [31:0] KBASE = 32'hC000_0000
) (
    input  logic [31:0] vaddr,
    input  logic        is_write,
    input  logic        user_mode,
    input  logic [31:0] leaf,
    output logic        deny,
    output logic [31:0] leaf_new
);
    logic [31:0] need;

    always_comb begin
        need = F_PRESENT;
        if (vaddr < KBASE || user_mode) need = need | F_USER;
        if (is_write)                   need = need | F_WRITE;
        deny     = |(need & ~leaf);
        leaf_new = leaf | F_ACCESSED | F_HASHED | (is_write ? F_DIRTY : 32'h0);
    end
endmodule

// File: rtl/ptw_counter.sv
module ptw_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter logic [31:0] KBASE      = 32'hC000_0000,
    parameter int          CNT_W      = 16,
    parameter int          PAGE_W     = 12,
    parameter int          ROOT_IDX_W = 10,
    parameter int          LEAF_IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_user_mode,
    output logic             busy,
    input  logic [31:0]      task_root,
    input  logic [31:0]      kern_root,
    output logic             mem_req,
    output logic [1:0]       mem_op,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_sc_ok,
    output logic             grant_valid,
    output logic [31:0]      grant_vaddr,
    output logic [31:0]      grant_old,
    output logic [31:0]      grant_new,
    output logic             fault_valid,
    output logic [CNT_W-1:0] reload_count
);
    localparam int BASE_W = 32 - PAGE_W;

    walk_state_t       st, st_nx;
    logic [31:0]       va_q, root_q, old_q, new_q;
    logic              wr_q, um_q;
    logic [BASE_W-1:0] tbl_q;
    logic              deny;
    logic [31:0]       leaf_new;
    logic              no_map;
    logic              sc_done;

    assign no_map  = (mem_rdata[31:PAGE_W] == '0);
    assign sc_done = (st == S_SC) && mem_ack && mem_sc_ok;

    ptw_perm #(.KBASE(KBASE)) u_perm (
        .vaddr    (va_q),
        .is_write (wr_q),
        .user_mode(um_q),
        .leaf     (mem_rdata),
        .deny     (deny),
        .leaf_new (leaf_new)
    );

    ptw_addr #(
        .PAGE_W    (PAGE_W),
        .ROOT_IDX_W(ROOT_IDX_W),
        .LEAF_IDX_W(LEAF_IDX_W)
    ) u_addr (
        .leaf_phase(st != S_ROOT),
        .root_base (root_q),
        .tbl_base  (tbl_q),
        .vaddr     (va_q),
        .addr      (mem_addr)
    );

    ptw_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (sc_done),
        .count(reload_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (req_valid) st_nx = S_ROOT;
            S_ROOT:  if (mem_ack)   st_nx = no_map ? S_FAULT : S_LR;
            S_LR:    if (mem_ack)   st_nx = deny ? S_FAULT : S_SC;
            S_SC:    if (mem_ack)   st_nx = mem_sc_ok ? S_GRANT : S_LR;
            S_GRANT: st_nx = S_IDLE;
            S_FAULT: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            um_q   <= 1'b0;
            root_q <= '0;
            tbl_q  <= '0;
            old_q  <= '0;
            new_q  <= '0;
        end else begin
            if (st == S_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                wr_q   <= req_write;
                um_q   <= req_user_mode;
                root_q <= (req_vaddr >= KBASE) ? kern_root : task_root;
            end
            if (st == S_ROOT && mem_ack) tbl_q <= mem_rdata[31:PAGE_W];
            if (st == S_LR && mem_ack) begin
                old_q <= mem_rdata;
                new_q <= leaf_new;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (st != S_IDLE);
        mem_req     = 1'b0;
        mem_op      = OP_READ;
        mem_wdata   = '0;
        grant_valid = 1'b0;
        fault_valid = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_ROOT:  mem_req = 1'b1;
            S_LR:    begin mem_req = 1'b1; mem_op = OP_LDRES; end
            S_SC:    begin mem_req = 1'b1; mem_op = OP_STCOND; mem_wdata = new_q; end
            S_GRANT: grant_valid = 1'b1;
            S_FAULT: fault_valid = 1'b1;
            default: ;
        endcase
        grant_vaddr = va_q;
        grant_old   = old_q;
        grant_new   = new_q;
    end

    // R10: a request stays put until acknowledged
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_op));

    // R8: grant and fault are exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && fault_valid));

    // R9: each grant is accompanied by one counter step
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> reload_count == $past(reload_count) + 1'b1);

    // R9: a fault leaves the counter alone
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $stable(reload_count));

    // R6: the store always carries referenced and hash-present
    p_sc_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_op == OP_STCOND |->
            (mem_wdata & (F_ACCESSED | F_HASHED)) == (F_ACCESSED | F_HASHED));

    // R5: a fault never follows a store attempt directly
    p_fault_nostore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(mem_op) != OP_STCOND);

    // R7: a lost reservation goes back to the reserved load
    p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_op == OP_STCOND && !mem_sc_ok |=>
            mem_req && mem_op == OP_LDRES);

    // R11: a pulse while busy does not restart the walk
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !grant_valid && !fault_valid |=> busy);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam logic [31:0] KB  = 32'hC000_0000;
    localparam int          CW  = 4;
    localparam logic [31:0] TR  = 32'h0001_0000;
    localparam logic [31:0] KR  = 32'h0002_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic req_user_mode = 1'b0;
    logic busy;
    logic mem_req;
    logic [1:0] mem_op;
    logic [31:0] mem_addr, mem_wdata;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_sc_ok = 1'b0;
    logic grant_valid, fault_valid;
    logic [31:0] grant_vaddr, grant_old, grant_new;
    logic [CW-1:0] reload_count;

    always #4 clk = ~clk;

    ptw_walker #(.KBASE(KB), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user_mode(req_user_mode), .busy(busy),
        .task_root(TR), .kern_root(KR), .mem_req(mem_req), .mem_op(mem_op),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_sc_ok(mem_sc_ok), .grant_valid(grant_valid),
        .grant_vaddr(grant_vaddr), .grant_old(grant_old), .grant_new(grant_new),
        .fault_valid(fault_valid), .reload_count(reload_count)
    );

    // memory model
    logic [31:0] mem [logic [31:0]];
    int latency = 0, lat = 0;
    int n_rd = 0, n_lr = 0, n_sc = 0, n_scfail = 0;
    int sc_fail_left = 0;
    bit poke_on = 0;
    logic [31:0] poke_val = '0;
    logic [31:0] first_rd_addr = '0, last_lr_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat < latency) lat = lat + 1;
            else begin
                lat = 0;
                mem_ack   <= 1'b1;
                mem_sc_ok <= 1'b0;
                case (mem_op)
                    2'd0: begin mem_rdata <= rd(mem_addr); n_rd++; first_rd_addr = mem_addr; end
                    2'd1: begin mem_rdata <= rd(mem_addr); n_lr++; last_lr_addr = mem_addr; end
                    default: begin
                        if (sc_fail_left > 0) begin
                            sc_fail_left--; n_scfail++;
                            if (poke_on) mem[mem_addr] = poke_val;
                        end else begin
                            mem[mem_addr] = mem_wdata;
                            mem_sc_ok <= 1'b1;
                            n_sc++;
                        end
                    end
                endcase
            end
        end
    end

    int tests = 0, fails = 0;
    int cyc = 0;
    logic [CW-1:0] exp_cnt = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // one walk; returns outcome sampled at the report cycle
    task automatic walk(input logic [31:0] va, input bit wr, input bit um,
                        output bit g, output bit f,
                        output logic [31:0] gv, output logic [31:0] go, output logic [31:0] gn);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user_mode = um; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g = 0; f = 0; gv = '0; go = '0; gn = '0;
        for (int i = 0; i < 200; i++) begin
            if (grant_valid || fault_valid) begin
                g = grant_valid; f = fault_valid;
                gv = grant_vaddr; go = grant_old; gn = grant_new;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] root_of(input logic [31:0] va);
        return ((va >= KB) ? KR : TR) + ((va >> 22) << 2);
    endfunction
    function automatic logic [31:0] leaf_of(input logic [31:0] ent, input logic [31:0] va);
        return (ent & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) << 2);
    endfunction

    initial begin
        bit g, f;
        logic [31:0] gv, go, gn;
        logic [31:0] va, ent, la, leaf, need, expn;
        int rd0, lr0, sc0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !grant_valid && !fault_valid, "R8 reset outputs quiet",
            {28'h0, busy, mem_req, grant_valid, fault_valid}, 32'h0);
        chk(reload_count == 0, "R9 reset count", 32'(reload_count), 32'h0);

        // sweep: write x user mode x region x leaf permission bits
        for (int c = 0; c < 64; c++) begin
            bit wr, um, kern;
            wr = c[0]; um = c[1]; kern = c[2];
            latency = c % 3;
            va   = kern ? (32'hC0AB_C000 | 32'(c)) : (32'h1234_5000 | 32'(c * 3));
            ent  = kern ? 32'h0004_0005 : 32'h0003_0ABC;
            mem[root_of(va)] = ent;
            la   = leaf_of(ent, va);
            leaf = 32'h20 | (c[3] ? 32'h1 : 0) | (c[4] ? 32'h4 : 0) | (c[5] ? 32'h400 : 0);
            mem[la] = leaf;
            need = 32'h1 | ((!kern || um) ? 32'h4 : 0) | (wr ? 32'h400 : 0);
            expn = leaf | 32'h102 | (wr ? 32'h80 : 0);
            sc0 = n_sc;
            walk(va, wr, um, g, f, gv, go, gn);
            chk(first_rd_addr == root_of(va), "R1 root address", first_rd_addr, root_of(va));
            chk(last_lr_addr == la, "R3 leaf address", last_lr_addr, la);
            if ((need & ~leaf) != 0) begin
                chk(f && !g, "R4 R5 denied access faults", {30'h0, g, f}, 32'h1);
                chk(n_sc == sc0 && rd(la) == leaf, "R5 no store on fault", rd(la), leaf);
            end else begin
                exp_cnt = exp_cnt + 1'b1;
                chk(g && !f, "R4 allowed access grants", {30'h0, g, f}, 32'h2);
                chk(gv == va && go == leaf, "R8 grant vaddr/old", go, leaf);
                chk(gn == expn, "R6 grant new value", gn, expn);
                chk(rd(la) == expn, "R6 stored leaf", rd(la), expn);
            end
            chk(reload_count == exp_cnt, "R9 reload count", 32'(reload_count), 32'(exp_cnt));
        end

        // R2: empty root entry
        latency = 1;
        va = 32'h4560_0000;
        mem[root_of(va)] = 32'h0000_0FFF;
        rd0 = n_rd; lr0 = n_lr;
        walk(va, 1'b0, 1'b1, g, f, gv, go, gn);
        chk(f && !g, "R2 no mapping faults", {30'h0, g, f}, 32'h1);
        chk(n_rd == rd0 + 1 && n_lr == lr0, "R2 no leaf access", 32'(n_lr - lr0), 32'h0);
        chk(reload_count == exp_cnt, "R9 fault keeps count", 32'(reload_count), 32'(exp_cnt));

        // R7: two lost reservations then success
        va = 32'h0804_8000; ent = 32'h0005_0000;
        mem[root_of(va)] = ent; la = leaf_of(ent, va);
        mem[la] = 32'h405;
        sc_fail_left = 2; poke_on = 0; lr0 = n_lr;
        walk(va, 1'b1, 1'b0, g, f, gv, go, gn);
        exp_cnt = exp_cnt + 1'b1;
        chk(g && n_lr == lr0 + 3, "R7 retry loads", 32'(n_lr - lr0), 32'h3);
        chk(rd(la) == 32'h587, "R7 final store", rd(la), 32'h587);
        chk(reload_count == exp_cnt, "R9 count after retry", 32'(reload_count), 32'(exp_cnt));

        // R7: lost reservation and leaf loses write flag -> recheck denies
        mem[la] = 32'h405;
        sc_fail_left = 1; poke_on = 1; poke_val = 32'h005; lr0 = n_lr;
        walk(va, 1'b1, 1'b0, g, f, gv, go, gn);
        poke_on = 0;
        chk(f && !g && n_lr == lr0 + 2, "R7 recheck denies", {30'h0, g, f}, 32'h1);
        chk(rd(la) == 32'h005, "R7 leaf untouched after deny", rd(la), 32'h005);
        chk(reload_count == exp_cnt, "R9 count after deny", 32'(reload_count), 32'(exp_cnt));

        // R11: pulses while busy and in the grant cycle are ignored
        latency = 2;
        mem[la] = 32'h005;
        @(negedge clk);
        req_vaddr = va; req_write = 1'b0; req_user_mode = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'hC000_1000; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !grant_valid && !fault_valid; i++) @(negedge clk);
        chk(grant_valid && grant_vaddr == va, "R11 first request kept", grant_vaddr, va);
        chk(grant_new == 32'h107, "R11 read-mode update", grant_new, 32'h107);
        rd0 = n_rd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(!busy && n_rd == rd0, "R11 grant-cycle pulse ignored", 32'(n_rd - rd0), 32'h0);
        exp_cnt = exp_cnt + 1'b1;
        chk(reload_count == exp_cnt, "R9 wrap count", 32'(reload_count), 32'(exp_cnt));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule